// File: doc/BRIEF.md
# DMA request conditioning and arbitration

This block sits in front of a two-channel DMA engine. It turns the external request pins into internal service requests and then picks one requester to serve. Each pin passes through a two-flop synchronizer. A per-channel enable gates the pin. The channel then treats the pin as either a level request or an edge request. In edge mode, a per-channel select chooses whether the rising or the falling transition raises a request. An edge request is held pending until the channel is granted. A level request stays asserted for as long as the pin is high.

The conditioned DMA requests compete with a vector of serial-channel requests. A single priority input decides whether the DMA channels rank above or below the serial channels. Once a grant is issued it stays fixed until the engine pulses done. The block also drives a per-channel acknowledge strobe. The strobe is high only while the engine reports a device access on behalf of that channel's grant. The pin may also be driven by a pacing timer rather than a peripheral, to time memory-to-memory moves. The block handles such a timer like any other source. Configuration arrives as static input ports.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, grant_vld_o is 0 and ack_o is all zero.
- R2: While pin_en_i[c] is 0, pin activity on req_pin_i[c] raises no request. An edge that occurs while the channel is disabled is not remembered once the channel is enabled.
- R3: In level mode (edge_mode_i[c]=0), the request is active while the synchronized pin is high. A pin raised between clock edges produces a grant on the third following rising clock edge. After done, a pin still held high is granted again, and a released pin is not.
- R4: In edge mode with edge_fall_i[c]=0, each rising pin transition produces exactly one grant. Holding the pin high and the falling transition produce no further grant.
- R5: In edge mode with edge_fall_i[c]=1, only the falling transition produces a grant.
- R6: With dma_first_i=1, a pending DMA channel wins over any pending serial request. With dma_first_i=0, any pending serial request wins over the DMA channels.
- R7: When both DMA channels are pending, channel index 0 wins over index 1.
- R8: Among serial requests, the lowest index wins. Serial request k is granted on the clock edge after it is raised in idle. Grant id encoding: 0 and 1 are DMA channels 0 and 1, and 2+k is serial request k.
- R9: While a grant is active and done_i is low, grant_vld_o and grant_id_o stay unchanged, whatever the request inputs do. A done pulse releases the grant, and a new grant can follow one cycle later.
- R10: ack_o[c] is 1 only while dev_access_i is high and the current grant is DMA channel c. A serial grant never raises any ack bit.
- R11: An edge request that arrives while another requester holds the grant stays pending and is granted after the engine releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin_i | input | NUM_DMA | Raw external request pins, asynchronous |
| pin_en_i | input | NUM_DMA | Per-channel request enable |
| edge_mode_i | input | NUM_DMA | 1 = edge sensing, 0 = level sensing |
| edge_fall_i | input | NUM_DMA | In edge mode: 1 = falling edge fires, 0 = rising edge fires |
| dma_first_i | input | 1 | 1 = DMA outranks serial requests |
| ser_req_i | input | NUM_SER | Competing serial-channel requests, already synchronous |
| done_i | input | 1 | Engine pulse ending the current service |
| dev_access_i | input | 1 | Engine is performing an access to the granted device |
| grant_vld_o | output | 1 | A grant is active |
| grant_id_o | output | $clog2(NUM_DMA+NUM_SER) | Granted requester id |
| ack_o | output | NUM_DMA | Per-channel acknowledge strobe |

## Verification
The hardest situation to reach is an edge request that arrives while the grant is held by someone else, combined with a simultaneous DMA-versus-serial or channel-0-versus-channel-1 contest. A request raised from idle is granted at once, so no contest ever forms that way. The stimulus first parks the grant on the highest serial line. It then raises the competing requests and waits out the synchronizer latency. Only after that does it drop the parking request and pulse done, so that all contenders are pending when the next arbitration happens. Exact grant latency through the synchronizer is checked cycle by cycle in level mode.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/dma_req_cond.sv
module dma_req_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic edge_fall_i,
  input  logic take_i,
  output logic req_o
);

  logic prev_q;
  logic pend_q, pend_d;
  logic rise_hit, fall_hit, edge_hit;

  always_comb begin
    rise_hit = lvl_i & ~prev_q;
    fall_hit = ~lvl_i & prev_q;
    edge_hit = edge_fall_i ? fall_hit : rise_hit;

    pend_d = pend_q;
    if (take_i)   pend_d = 1'b0;
    if (edge_hit) pend_d = 1'b1;
    if (!en_i || !edge_mode_i) pend_d = 1'b0;

    req_o = en_i & (edge_mode_i ? pend_q : lvl_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  // R4
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_i && edge_mode_i));

  // R2
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pend_q);

endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb
  import dma_req_pkg::*;
#(
  parameter int NUM_DMA = 2,
  parameter int NUM_SER = 4,
  localparam int TOT = NUM_DMA + NUM_SER,
  localparam int IDW = $clog2(TOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TOT-1:0]     req_i,
  input  logic               dma_first_i,
  input  logic               done_i,
  output logic               grant_vld_o,
  output logic [IDW-1:0]     grant_id_o,
  output logic [NUM_DMA-1:0] take_o
);

  arb_state_e     state_q, state_d;
  logic [IDW-1:0] id_q, id_d;
  logic           dma_hit, ser_hit, any_hit;
  logic [IDW-1:0] dma_idx, ser_idx, win_id;

  always_comb begin
    dma_hit = 1'b0;
    dma_idx = '0;
    for (int i = NUM_DMA - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        dma_hit = 1'b1;
        dma_idx = IDW'(i);
      end
    end
    ser_hit = 1'b0;
    ser_idx = '0;
    for (int i = NUM_SER - 1; i >= 0; i--) begin
      if (req_i[NUM_DMA + i]) begin
        ser_hit = 1'b1;
        ser_idx = IDW'(NUM_DMA + i);
      end
    end
    any_hit = dma_hit | ser_hit;
    if (dma_first_i) win_id = dma_hit ? dma_idx : ser_idx;
    else             win_id = ser_hit ? ser_idx : dma_idx;
  end

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    take_o  = '0;
    case (state_q)
      ARB_IDLE: begin
        if (any_hit) begin
          state_d = ARB_BUSY;
          id_d    = win_id;
          for (int c = 0; c < NUM_DMA; c++) begin
            if (win_id == IDW'(c)) take_o[c] = 1'b1;
          end
        end
      end
      default: begin
        if (done_i) state_d = ARB_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end

  assign grant_vld_o = (state_q == ARB_BUSY);
  assign grant_id_o  = id_q;

  // R9
  grant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !done_i) |=> (grant_vld_o && $stable(grant_id_o)));

  // R6
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld_o) |-> ((($past(req_i) >> grant_id_o) & TOT'(1)) != '0));

  // R7
  take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_DMA     = 2,
  parameter int NUM_SER     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int TOT = NUM_DMA + NUM_SER,
  localparam int IDW = $clog2(TOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DMA-1:0] req_pin_i,
  input  logic [NUM_DMA-1:0] pin_en_i,
  input  logic [NUM_DMA-1:0] edge_mode_i,
  input  logic [NUM_DMA-1:0] edge_fall_i,
  input  logic               dma_first_i,
  input  logic [NUM_SER-1:0] ser_req_i,
  input  logic               done_i,
  input  logic               dev_access_i,
  output logic               grant_vld_o,
  output logic [IDW-1:0]     grant_id_o,
  output logic [NUM_DMA-1:0] ack_o
);

  logic [NUM_DMA-1:0] pin_sync;
  logic [NUM_DMA-1:0] dma_req;
  logic [NUM_DMA-1:0] take;

  dma_req_sync #(.W(NUM_DMA), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (req_pin_i),
    .sync_o  (pin_sync)
  );

  for (genvar c = 0; c < NUM_DMA; c++) begin : g_chan
    dma_req_cond u_cond (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_i       (pin_sync[c]),
      .en_i        (pin_en_i[c]),
      .edge_mode_i (edge_mode_i[c]),
      .edge_fall_i (edge_fall_i[c]),
      .take_i      (take[c]),
      .req_o       (dma_req[c])
    );

    assign ack_o[c] = dev_access_i & grant_vld_o & (grant_id_o == IDW'(c));
  end

  dma_req_arb #(.NUM_DMA(NUM_DMA), .NUM_SER(NUM_SER)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       ({ser_req_i, dma_req}),
    .dma_first_i (dma_first_i),
    .done_i      (done_i),
    .grant_vld_o (grant_vld_o),
    .grant_id_o  (grant_id_o),
    .take_o      (take)
  );

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  // R10
  ser_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && (grant_id_o >= IDW'(NUM_DMA))) |-> (ack_o == '0));

endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DMA = 2;
  localparam int NUM_SER = 4;
  localparam int IDW = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_DMA-1:0] req_pin = '0;
  logic [NUM_DMA-1:0] pin_en = '0;
  logic [NUM_DMA-1:0] edge_mode = '0;
  logic [NUM_DMA-1:0] edge_fall = '0;
  logic               dma_first = 1'b1;
  logic [NUM_SER-1:0] ser_req = '0;
  logic               done = 1'b0;
  logic               dev_access = 1'b0;
  logic               grant_vld;
  logic [IDW-1:0]     grant_id;
  logic [NUM_DMA-1:0] ack;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  dma_req_arbiter #(.NUM_DMA(NUM_DMA), .NUM_SER(NUM_SER)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_pin_i    (req_pin),
    .pin_en_i     (pin_en),
    .edge_mode_i  (edge_mode),
    .edge_fall_i  (edge_fall),
    .dma_first_i  (dma_first),
    .ser_req_i    (ser_req),
    .done_i       (done),
    .dev_access_i (dev_access),
    .grant_vld_o  (grant_vld),
    .grant_id_o   (grant_id),
    .ack_o        (ack)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_done();
    done = 1'b1;
    tick(1);
    done = 1'b0;
  endtask

  task automatic quiesce();
    pin_en = '0; req_pin = '0; ser_req = '0; edge_mode = '0; edge_fall = '0;
    dma_first = 1'b1; dev_access = 1'b0;
    tick(4);
    if (grant_vld) pulse_done();
    tick(2);
  endtask

  task automatic park();
    ser_req = 4'b1000;
    tick(1);
    chk("park grant id", int'(grant_id), 5);
  endtask

  task automatic t_reset();
    chk("R1 grant_vld after reset", int'(grant_vld), 0);
    chk("R1 ack after reset", int'(ack), 0);
  endtask

  task automatic t_disabled();
    pin_en = 2'b00; edge_mode = 2'b00;
    req_pin = 2'b01;
    tick(6);
    chk("R2 level pin disabled", int'(grant_vld), 0);
    req_pin = 2'b00;
    tick(4);
    edge_mode = 2'b10;
    req_pin = 2'b10;
    tick(6);
    pin_en = 2'b10;
    tick(6);
    chk("R2 edge while disabled not kept", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_level();
    pin_en = 2'b01; edge_mode = 2'b00;
    req_pin = 2'b01;
    tick(2);
    chk("R3 no grant before sync latency", int'(grant_vld), 0);
    tick(1);
    chk("R3 grant on third edge", int'(grant_vld), 1);
    chk("R3 grant id ch0", int'(grant_id), 0);
    pulse_done();
    tick(1);
    chk("R3 held level regranted", int'(grant_vld), 1);
    chk("R3 regrant id", int'(grant_id), 0);
    req_pin = 2'b00;
    tick(4);
    pulse_done();
    tick(3);
    chk("R3 released level no grant", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_rise();
    pin_en = 2'b10; edge_mode = 2'b10; edge_fall = 2'b00;
    req_pin = 2'b10;
    tick(6);
    chk("R4 rising edge grant", int'(grant_vld), 1);
    chk("R4 rising edge id", int'(grant_id), 1);
    pulse_done();
    tick(6);
    chk("R4 held high single grant", int'(grant_vld), 0);
    req_pin = 2'b00;
    tick(6);
    chk("R4 falling edge ignored", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_fall();
    pin_en = 2'b01; edge_mode = 2'b01; edge_fall = 2'b01;
    req_pin = 2'b01;
    tick(6);
    chk("R5 rising ignored in fall mode", int'(grant_vld), 0);
    req_pin = 2'b00;
    tick(6);
    chk("R5 falling edge grant", int'(grant_vld), 1);
    chk("R5 falling edge id", int'(grant_id), 0);
    pulse_done();
    tick(3);
    chk("R5 single falling grant", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_prio();
    pin_en = 2'b01; edge_mode = 2'b00; dma_first = 1'b1;
    park();
    req_pin = 2'b01;
    ser_req = 4'b1010;
    tick(6);
    ser_req = 4'b0010;
    pulse_done();
    tick(1);
    chk("R6 dma_first DMA wins", int'(grant_id), 0);
    dma_first = 1'b0;
    pulse_done();
    tick(1);
    chk("R6 serial first serial wins", int'(grant_id), 3);
    quiesce();
  endtask

  task automatic t_chan();
    pin_en = 2'b11; edge_mode = 2'b11; edge_fall = 2'b00;
    park();
    req_pin = 2'b11;
    tick(6);
    ser_req = '0;
    pulse_done();
    tick(1);
    chk("R7 channel 0 wins tie", int'(grant_id), 0);
    pulse_done();
    tick(1);
    chk("R11 pending ch1 served after", int'(grant_vld), 1);
    chk("R11 pending ch1 id", int'(grant_id), 1);
    pulse_done();
    tick(3);
    chk("R11 no extra grant", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_ser();
    ser_req = 4'b1100;
    tick(1);
    chk("R8 lowest serial wins", int'(grant_id), 4);
    pulse_done();
    ser_req = 4'b1001;
    tick(1);
    chk("R8 serial 0 id", int'(grant_id), 2);
    ser_req = '0;
    pulse_done();
    tick(1);
    chk("R8 no request no grant", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_hold();
    ser_req = 4'b0001;
    tick(1);
    chk("R9 initial grant id", int'(grant_id), 2);
    ser_req = 4'b1000;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      chk("R9 grant held vld", int'(grant_vld), 1);
      chk("R9 grant held id", int'(grant_id), 2);
    end
    pulse_done();
    chk("R9 released by done", int'(grant_vld), 0);
    tick(1);
    chk("R9 next grant after done", int'(grant_id), 5);
    ser_req = '0;
    pulse_done();
    pulse_done();
    tick(1);
    chk("R9 done while idle no grant", int'(grant_vld), 0);
    quiesce();
  endtask

  task automatic t_ack();
    pin_en = 2'b10; edge_mode = 2'b00;
    req_pin = 2'b10;
    tick(3);
    chk("R10 grant ch1", int'(grant_id), 1);
    chk("R10 no ack without access", int'(ack), 0);
    dev_access = 1'b1;
    #1;
    chk("R10 ack ch1 during access", int'(ack), 2);
    dev_access = 1'b0;
    #1;
    chk("R10 ack drops after access", int'(ack), 0);
    req_pin = 2'b00;
    tick(4);
    pulse_done();
    tick(2);
    ser_req = 4'b0001;
    tick(1);
    dev_access = 1'b1;
    #1;
    chk("R10 serial grant no ack", int'(ack), 0);
    quiesce();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_disabled();
    t_level();
    t_rise();
    t_fall();
    t_prio();
    t_chan();
    t_ser();
    t_hold();
    t_ack();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule